// File: doc/BRIEF.md
# PCIe Bridge Interrupt Status Controller

This block gathers every interrupt source of a PCIe root-port bridge into one place. Software reaches it through a 32-bit register port. Each source group has a status register and a mask register. The groups are two banks of message-signalled vectors, four legacy level lines and a set of miscellaneous error and event pulses.

An inbound message-signalled write arrives as a strobe and a data word. The data word is the vector number, and it selects one of 64 status bits. Vectors 0 to 31 sit in the low bank and vectors 32 to 63 in the high bank. The legacy lines first pass through a two-stage synchroniser; their status bits then mirror the line levels. Miscellaneous pulses latch into fixed bit positions.

Status bits clear when software writes a one to them. A mask bit of one lets its source reach the group's interrupt line. Each of the four groups drives its own registered interrupt output. These outputs go to the system interrupt controller.

Top module: `bih_top`

## Requirements
- R1: After reset, every status register, every mask register and the control register at 0x460 read 0, and all four interrupt outputs are low.
- R2: A strobed message write with data value D below 64 sets status bit D of the low bank (0x440) when D < 32, and bit D-32 of the high bank (0x444) when D >= 32. The bit appears on the edge that samples the strobe, but only when control bit 0 (capture enable) and control bit 15 (record enable) were both already set; with either bit clear, nothing is recorded.
- R3: A message write whose data value is 64 or above changes no status bit.
- R4: Writing a word to a latching status register (0x400, 0x440, 0x444) clears every bit where the word has a one and leaves the bits where it has a zero. If a new event for a bit arrives on the same edge as a clear of that bit, the bit stays set.
- R5: Each interrupt output is high in a cycle exactly when, one edge earlier, the group's status ANDed with its mask (0x404 misc, 0x424 legacy, 0x448 low bank, 0x44C high bank) was non-zero. A mask bit of 1 enables its source.
- R6: Legacy status (0x420, bits 0 to 3 for lines A to D) equals the line levels sampled three edges earlier. Writing ones to it has no effect while a line is high, and the bit drops once the line falls.
- R7: Miscellaneous pulses latch only at bits 0, 1, 4, 5, 6, 7, 16, 17, 18, 20, 22, 23, 24, 25 and 26. These are: message available, message-queue overflow, completer error, requester error, inbound translation error, outbound translation error, fatal, non-fatal and correctable advanced errors, unsupported request, non-fatal and fatal device error, link down, autonomous bandwidth change and bandwidth change. All other misc status and mask bits read 0.
- R8: The low bank drives only irq_msi_lo and the high bank drives only irq_msi_hi.
- R9: Reads of any address outside the map return 0, and writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr (combinational) |
| msi_valid | input | 1 | Inbound message write strobe |
| msi_data | input | 32 | Inbound message data (vector number) |
| intx_in | input | 4 | Legacy lines A..D, asynchronous levels |
| misc_evt | input | 32 | Miscellaneous event pulses, one per bit |
| irq_msi_lo | output | 1 | Low bank interrupt |
| irq_msi_hi | output | 1 | High bank interrupt |
| irq_intx | output | 1 | Legacy interrupt |
| irq_misc | output | 1 | Miscellaneous interrupt |

## Verification
The hardest case to reach from the ports is a clearing write and a new event that hit the same bit on the same edge. The bench reaches it directly by driving the message strobe and the status write in the same cycle. A random phase then produces many more such collisions across both banks and the misc group. Legacy lines are held high through a clearing write to show that the status bit stays up. A behavioural reference model follows every edge and checks the interrupt lines and the read data on each cycle.

// File: rtl/bih_pkg.sv
package bih_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_MISC_ST = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_MISC_MK = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_LEG_ST  = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_LEG_MK  = 12'h424;
    localparam logic [ADDR_W-1:0] OFF_LO_ST   = 12'h440;
    localparam logic [ADDR_W-1:0] OFF_HI_ST   = 12'h444;
    localparam logic [ADDR_W-1:0] OFF_LO_MK   = 12'h448;
    localparam logic [ADDR_W-1:0] OFF_HI_MK   = 12'h44C;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h460;

    localparam logic [DATA_W-1:0] MISC_VALID = 32'h07D7_00F3;

    localparam int CTRL_CAP_BIT = 0;
    localparam int CTRL_REC_BIT = 15;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MISC_ST,
        SEL_MISC_MK,
        SEL_LEG_ST,
        SEL_LEG_MK,
        SEL_LO_ST,
        SEL_HI_ST,
        SEL_LO_MK,
        SEL_HI_MK,
        SEL_CTRL
    } reg_sel_e;

endpackage

// File: rtl/bih_regdec.sv
module bih_regdec
    import bih_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            OFF_MISC_ST: sel = SEL_MISC_ST;
            OFF_MISC_MK: sel = SEL_MISC_MK;
            OFF_LEG_ST:  sel = SEL_LEG_ST;
            OFF_LEG_MK:  sel = SEL_LEG_MK;
            OFF_LO_ST:   sel = SEL_LO_ST;
            OFF_HI_ST:   sel = SEL_HI_ST;
            OFF_LO_MK:   sel = SEL_LO_MK;
            OFF_HI_MK:   sel = SEL_HI_MK;
            OFF_CTRL:    sel = SEL_CTRL;
            default:     sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/bih_sync.sv
module bih_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/bih_status_bank.sv
module bih_status_bank #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1,
    parameter bit           LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         st_wr,
    input  logic         mk_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);

    logic [W-1:0] clr;
    logic [W-1:0] status_nx;

    always_comb begin
        clr       = st_wr ? wdata : '0;
        status_nx = LEVEL ? set : ((status & ~clr) | set);
        status_nx = status_nx & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_nx;
            if (mk_wr) begin
                mask <= wdata & VALID;
            end
            irq <= |(status & mask);
        end
    end

endmodule

// File: rtl/bih_top.sv
module bih_top
    import bih_pkg::*;
#(
    parameter int MSI_VECS = 64,
    parameter int LEG_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              msi_valid,
    input  logic [31:0]       msi_data,
    input  logic [LEG_W-1:0]  intx_in,
    input  logic [31:0]       misc_evt,
    output logic              irq_msi_lo,
    output logic              irq_msi_hi,
    output logic              irq_intx,
    output logic              irq_misc
);

    localparam int BANK_W = MSI_VECS / 2;
    localparam int IDX_W  = $clog2(MSI_VECS);

    reg_sel_e sel;

    logic [31:0]       ctrl_q;
    logic              ctrl_on;
    logic              msi_hit;
    logic [IDX_W-1:0]  msi_idx;
    logic [MSI_VECS-1:0] msi_set;

    logic [31:0]       misc_st, misc_mk;
    logic [LEG_W-1:0]  leg_st, leg_mk, leg_sync;
    logic [BANK_W-1:0] lo_st, lo_mk, hi_st, hi_mk;

    bih_regdec u_dec (
        .addr (addr),
        .sel  (sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && sel == SEL_CTRL) begin
            ctrl_q <= '0;
            ctrl_q[CTRL_CAP_BIT] <= wdata[CTRL_CAP_BIT];
            ctrl_q[CTRL_REC_BIT] <= wdata[CTRL_REC_BIT];
        end
    end

    assign ctrl_on = ctrl_q[CTRL_CAP_BIT] & ctrl_q[CTRL_REC_BIT];
    assign msi_hit = msi_valid & ctrl_on & (msi_data < 32'(MSI_VECS));
    assign msi_idx = msi_data[IDX_W-1:0];

    always_comb begin
        msi_set = '0;
        if (msi_hit) begin
            msi_set[msi_idx] = 1'b1;
        end
    end

    bih_sync #(.W(LEG_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (intx_in),
        .q     (leg_sync)
    );

    bih_status_bank #(.W(32), .VALID(MISC_VALID), .LEVEL(1'b0)) u_misc (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (misc_evt),
        .st_wr  (wr_en && sel == SEL_MISC_ST),
        .mk_wr  (wr_en && sel == SEL_MISC_MK),
        .wdata  (wdata),
        .status (misc_st),
        .mask   (misc_mk),
        .irq    (irq_misc)
    );

    bih_status_bank #(.W(LEG_W), .VALID({LEG_W{1'b1}}), .LEVEL(1'b1)) u_leg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (leg_sync),
        .st_wr  (wr_en && sel == SEL_LEG_ST),
        .mk_wr  (wr_en && sel == SEL_LEG_MK),
        .wdata  (wdata[LEG_W-1:0]),
        .status (leg_st),
        .mask   (leg_mk),
        .irq    (irq_intx)
    );

    bih_status_bank #(.W(BANK_W), .VALID({BANK_W{1'b1}}), .LEVEL(1'b0)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (msi_set[BANK_W-1:0]),
        .st_wr  (wr_en && sel == SEL_LO_ST),
        .mk_wr  (wr_en && sel == SEL_LO_MK),
        .wdata  (wdata[BANK_W-1:0]),
        .status (lo_st),
        .mask   (lo_mk),
        .irq    (irq_msi_lo)
    );

    bih_status_bank #(.W(BANK_W), .VALID({BANK_W{1'b1}}), .LEVEL(1'b0)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (msi_set[MSI_VECS-1:BANK_W]),
        .st_wr  (wr_en && sel == SEL_HI_ST),
        .mk_wr  (wr_en && sel == SEL_HI_MK),
        .wdata  (wdata[BANK_W-1:0]),
        .status (hi_st),
        .mask   (hi_mk),
        .irq    (irq_msi_hi)
    );

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_MISC_ST: rdata = misc_st;
            SEL_MISC_MK: rdata = misc_mk;
            SEL_LEG_ST:  rdata = 32'(leg_st);
            SEL_LEG_MK:  rdata = 32'(leg_mk);
            SEL_LO_ST:   rdata = 32'(lo_st);
            SEL_HI_ST:   rdata = 32'(hi_st);
            SEL_LO_MK:   rdata = 32'(lo_mk);
            SEL_HI_MK:   rdata = 32'(hi_mk);
            SEL_CTRL:    rdata = ctrl_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/bih_checker.sv
module bih_checker
    import bih_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        msi_valid,
    input logic [31:0] msi_data,
    input logic [3:0]  intx_in,
    input logic        ctrl_on,
    input logic [31:0] lo_st,
    input logic [31:0] hi_st,
    input logic [31:0] lo_mk,
    input logic [31:0] hi_mk,
    input logic [3:0]  leg_st,
    input logic [31:0] misc_st,
    input logic        irq_msi_lo,
    input logic        irq_msi_hi
);

    logic [63:0] all_st;
    logic [1:0]  cyc;

    assign all_st = {hi_st, lo_st};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && ctrl_on && msi_data < 32'd64) |=> all_st[$past(msi_data[5:0])]);

    p_big_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_data >= 32'd64 && !wr_en) |=> $stable(all_st));

    p_irq_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lo_st & lo_mk)) |=> irq_msi_lo);

    p_irq_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(hi_st & hi_mk)) |=> !irq_msi_hi);

    p_leg_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (leg_st == $past(intx_in, 3)));

    p_misc_holes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_st & ~MISC_VALID) == 32'd0);

endmodule

bind bih_top bih_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .msi_valid  (msi_valid),
    .msi_data   (msi_data),
    .intx_in    (intx_in),
    .ctrl_on    (ctrl_on),
    .lo_st      (lo_st),
    .hi_st      (hi_st),
    .lo_mk      (lo_mk),
    .hi_mk      (hi_mk),
    .leg_st     (leg_st),
    .misc_st    (misc_st),
    .irq_msi_lo (irq_msi_lo),
    .irq_msi_hi (irq_msi_hi)
);

// File: tb/bih_top_bench.sv
`timescale 1ns/1ps
module bih_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_data = '0;
    logic [3:0]  intx_in = '0;
    logic [31:0] misc_evt = '0;
    logic        irq_msi_lo, irq_msi_hi, irq_intx, irq_misc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [31:0] MV = 32'h07D7_00F3;

    always #2.5 clk = ~clk;

    bih_top u_bih_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .msi_valid(msi_valid), .msi_data(msi_data),
        .intx_in(intx_in), .misc_evt(misc_evt), .irq_msi_lo(irq_msi_lo),
        .irq_msi_hi(irq_msi_hi), .irq_intx(irq_intx), .irq_misc(irq_misc)
    );

    // behavioural reference model
    logic [63:0] m_msi;
    logic [31:0] m_misc, m_mmisc, m_mlo, m_mhi, m_ctrl;
    logic [3:0]  m_leg, m_mleg, m_s1, m_s2, m_irq;

    always @(posedge clk) begin
        logic [63:0] n_msi;
        logic [31:0] n_misc;
        if (!rst_n) begin
            m_msi = '0; m_misc = '0; m_mmisc = '0; m_mlo = '0; m_mhi = '0;
            m_ctrl = '0; m_leg = '0; m_mleg = '0; m_s1 = '0; m_s2 = '0; m_irq = '0;
        end else begin
            m_irq[0] = (m_msi[31:0] & m_mlo) != 0;
            m_irq[1] = (m_msi[63:32] & m_mhi) != 0;
            m_irq[2] = (m_leg & m_mleg) != 0;
            m_irq[3] = (m_misc & m_mmisc) != 0;
            n_msi  = m_msi;
            n_misc = m_misc;
            if (wr_en) begin
                case (addr)
                    12'h400: n_misc = n_misc & ~wdata;
                    12'h440: n_msi[31:0] = n_msi[31:0] & ~wdata;
                    12'h444: n_msi[63:32] = n_msi[63:32] & ~wdata;
                    default: ;
                endcase
            end
            if (msi_valid && m_ctrl[0] && m_ctrl[15] && msi_data < 64)
                n_msi[msi_data] = 1'b1;
            n_misc = (n_misc | misc_evt) & MV;
            if (wr_en) begin
                case (addr)
                    12'h404: m_mmisc = wdata & MV;
                    12'h424: m_mleg = wdata[3:0];
                    12'h448: m_mlo = wdata;
                    12'h44C: m_mhi = wdata;
                    12'h460: m_ctrl = wdata & 32'h0000_8001;
                    default: ;
                endcase
            end
            m_msi = n_msi;
            m_misc = n_misc;
            m_leg = m_s2;
            m_s2 = m_s1;
            m_s1 = intx_in;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h400: return m_misc;
            12'h404: return m_mmisc;
            12'h420: return {28'd0, m_leg};
            12'h424: return {28'd0, m_mleg};
            12'h440: return m_msi[31:0];
            12'h444: return m_msi[63:32];
            12'h448: return m_mlo;
            12'h44C: return m_mhi;
            12'h460: return m_ctrl;
            default: return 32'd0;
        endcase
    endfunction

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            n_tests++;
            if ({irq_misc, irq_intx, irq_msi_hi, irq_msi_lo} !== m_irq) begin
                n_fail++;
                $display("FAIL R5 cycle irq lines got %b exp %b", {irq_misc, irq_intx, irq_msi_hi, irq_msi_lo}, m_irq);
            end
            n_tests++;
            if (rdata !== exp_rd(addr)) begin
                n_fail++;
                $display("FAIL R4 cycle rdata @%h got %h exp %h", addr, rdata, exp_rd(addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic msi(input logic [31:0] d);
        @(negedge clk); msi_valid = 1'b1; msi_data = d;
        @(negedge clk); msi_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #0.5; d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h400, v); chk("R1 misc status", v, 0);
        rd(12'h440, v); chk("R1 low status", v, 0);
        rd(12'h44C, v); chk("R1 high mask", v, 0);
        rd(12'h460, v); chk("R1 control", v, 0);
        chk("R1 irqs", {28'd0, irq_misc, irq_intx, irq_msi_hi, irq_msi_lo}, 0);
        // R2 enable gating
        msi(5); rd(12'h440, v); chk("R2 disabled capture", v, 0);
        wr(12'h460, 32'h1); msi(5); rd(12'h440, v); chk("R2 record bit clear", v, 0);
        wr(12'h460, 32'h8001); msi(5); rd(12'h440, v); chk("R2 low vector 5", v, 32'h20);
        msi(40); rd(12'h444, v); chk("R2 high vector 40", v, 32'h100);
        // R3 out of range
        msi(64); msi(32'hFFFF_FFFF);
        rd(12'h440, v); chk("R3 low unchanged", v, 32'h20);
        rd(12'h444, v); chk("R3 high unchanged", v, 32'h100);
        // R4 write-one-to-clear
        wr(12'h440, 0); rd(12'h440, v); chk("R4 zero write keeps", v, 32'h20);
        wr(12'h440, 32'h20); rd(12'h440, v); chk("R4 one clears", v, 0);
        @(negedge clk); wr_en = 1'b1; addr = 12'h440; wdata = 32'h80; msi_valid = 1'b1; msi_data = 7;
        @(negedge clk); wr_en = 1'b0; msi_valid = 1'b0;
        rd(12'h440, v); chk("R4 set wins over clear", v, 32'h80);
        // R5 / R8 masking and separate lines
        wr(12'h448, 32'h80); @(negedge clk);
        chk("R5 low line on", {31'd0, irq_msi_lo}, 1);
        chk("R8 high line off", {31'd0, irq_msi_hi}, 0);
        wr(12'h44C, 32'h100); @(negedge clk);
        chk("R8 high line on", {31'd0, irq_msi_hi}, 1);
        wr(12'h448, 0); @(negedge clk);
        chk("R5 mask blocks", {31'd0, irq_msi_lo}, 0);
        // R6 legacy lines
        @(negedge clk); intx_in = 4'b0101;
        repeat (3) @(negedge clk);
        rd(12'h420, v); chk("R6 follows level", v, 5);
        wr(12'h420, 32'hF); rd(12'h420, v); chk("R6 clear ignored while high", v, 5);
        wr(12'h424, 32'h4); @(negedge clk);
        chk("R6 legacy line", {31'd0, irq_intx}, 1);
        @(negedge clk); intx_in = 4'b0000;
        repeat (4) @(negedge clk);
        rd(12'h420, v); chk("R6 drops with line", v, 0);
        // R7 misc bit map
        @(negedge clk); misc_evt = 32'hFFFF_FFFF;
        @(negedge clk); misc_evt = 0;
        rd(12'h400, v); chk("R7 implemented bits", v, MV);
        wr(12'h404, 32'hFFFF_FFFF); rd(12'h404, v); chk("R7 mask holes", v, MV);
        wr(12'h400, 32'h0000_00F0); rd(12'h400, v); chk("R7 partial clear", v, MV & ~32'hF0);
        // R9 unmapped
        wr(12'h410, 32'hFFFF_FFFF); rd(12'h410, v); chk("R9 unmapped read", v, 0);
        rd(12'h400, v); chk("R9 no side effect", v, MV & ~32'hF0);
        // random phase, compared each cycle by the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            msi_valid = ($urandom_range(0, 2) == 0);
            msi_data  = ($urandom_range(0, 7) == 0) ? $urandom : $urandom_range(0, 63);
            misc_evt  = ($urandom_range(0, 5) == 0) ? $urandom : 0;
            if ($urandom_range(0, 15) == 0) intx_in = 4'($urandom);
            wr_en = ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 9))
                0: addr = 12'h400; 1: addr = 12'h404; 2: addr = 12'h420;
                3: addr = 12'h424; 4: addr = 12'h440; 5: addr = 12'h444;
                6: addr = 12'h448; 7: addr = 12'h44C; 8: addr = 12'h460;
                default: addr = 12'h408;
            endcase
            wdata = (addr == 12'h460) ? 32'h8001 : $urandom;
        end
        @(negedge clk); wr_en = 0; msi_valid = 0; misc_evt = 0;
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule